// File: doc/BRIEF.md
# Fractional Reference Clock Divider

This block produces a reference output clock from one of several selectable source strobes. The divide factor is two times N + M/512. N is a 15-bit integer and M is a 9-bit fractional trim. All logic runs on one clock. Each source is a single-cycle tick strobe in that clock domain, and one tick stands for one source cycle.

Software sets up the block through a small register interface with two registers. The control register holds the source select, the on and output-enable bits, a staged integer divisor, a self-clearing divider-switch request and a read-only active flag. A trim register holds the staged fractional value. Staged divisor values have no effect until a switch request moves them into the running divider. The source select is locked while the divider is running.

The fractional part comes from a 9-bit phase accumulator. On every half-period boundary the accumulator adds M. When that addition carries out, the next half-period is one source tick longer.

Top module: `refclk_frac_div`

## Requirements
- R1: The control register is at offset 0x00. Its fields are: source select in bits 3:0, active (read-only) in bit 8, switch request in bit 9, output enable in bit 12, on in bit 15, and staged N in bits 30:16. The trim register is at offset 0x10 and holds staged M in bits 31:23. All other bits read as zero.
- R2: With N > 0 and M = 0, the output holds each level for exactly N selected-source ticks.
- R3: With N > 0, every half-period boundary adds M to a 9-bit accumulator that starts at zero. A carry out lengthens the following half-period to N + 1 ticks. A full period therefore averages 2·(N + M/512) ticks; for N = 2 and M = 256 each period is 5 ticks.
- R4: With N = 0, the source passes through undivided. The output is high in the cycle after each selected tick and low otherwise.
- R5: Writing bit 9 of the control register as 1 requests a switch. Staged N and M take effect only through this request. The request clears on the cycle the transfer happens: at once when the divider is idle, or at the next half-period boundary when it is running.
- R6: A write to the source select field is ignored while the active bit is 1 and accepted while it is 0.
- R7: The active bit rises one cycle after on is seen set. After on clears, the active bit drops when the current half-period ends. While the block is not active, the output is low.
- R8: With output enable at 0, the output is low even when the divider is running.
- R9: After reset both registers read zero and the output is low.
- R10: Only the selected source advances the divider. A select value at or above the number of sources selects no ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | NSRC | One tick strobe per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the addressed register |
| ref_o | output | 1 | Divided reference output |

## Verification
The assertions assume several things about the inputs:
- each source tick is a one-cycle strobe sampled on the block clock;
- writes are single-cycle pulses;
- the select lock relies only on the active flag seen in the cycle of the write.

The bench drives all inputs a short time after each rising edge and so keeps within these assumptions. It runs a fixed-rate source (every cycle), several slower periodic sources and pseudo-random sources. It also uses a select value that points at no source. It checks the output and the control readback every cycle against a behavioural model.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int SEL_W   = 4;
  localparam int INT_W   = 15;
  localparam int FRAC_W  = 9;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h00;
  localparam logic [ADDR_W-1:0] TRIM_OFS = 8'h10;
  localparam int ACT_BIT = 8;
  localparam int SW_BIT  = 9;
  localparam int OE_BIT  = 12;
  localparam int ON_BIT  = 15;
  localparam int N_LO    = 16;
  localparam int M_LO    = 23;
endpackage

// File: rtl/refclk_src_mux.sv
module refclk_src_mux
  import refclk_pkg::*;
#(
  parameter int NSRC = 12
) (
  input  logic [NSRC-1:0]  src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_hit
    assign hit[g] = (sel_i == SEL_W'(g)) & src_i[g];
  end

  assign tick_o = |hit;
endmodule

// File: rtl/refclk_regs.sv
module refclk_regs
  import refclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              active_i,
  input  logic              sw_done_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              on_o,
  output logic              oe_o,
  output logic              req_o,
  output logic [INT_W-1:0]  stg_n_o,
  output logic [FRAC_W-1:0] stg_m_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic ctrl_wr, trim_wr, req_set;
  logic unused_wbits;

  assign ctrl_wr = we_i && (addr_i == CTRL_OFS);
  assign trim_wr = we_i && (addr_i == TRIM_OFS);
  assign req_set = ctrl_wr && wdata_i[SW_BIT];
  assign unused_wbits = ^{wdata_i[8:4], wdata_i[11:10], wdata_i[14:13]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o   <= '0;
      on_o    <= 1'b0;
      oe_o    <= 1'b0;
      req_o   <= 1'b0;
      stg_n_o <= '0;
      stg_m_o <= '0;
    end else begin
      if (ctrl_wr) begin
        if (!active_i) sel_o <= wdata_i[SEL_W-1:0];
        on_o    <= wdata_i[ON_BIT];
        oe_o    <= wdata_i[OE_BIT];
        stg_n_o <= wdata_i[N_LO+INT_W-1:N_LO];
      end
      if (trim_wr) stg_m_o <= wdata_i[M_LO+FRAC_W-1:M_LO];
      req_o <= req_set || (req_o && !sw_done_i);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_OFS) begin
      rdata_o[SEL_W-1:0]           = sel_o;
      rdata_o[ACT_BIT]             = active_i;
      rdata_o[SW_BIT]              = req_o;
      rdata_o[OE_BIT]              = oe_o;
      rdata_o[ON_BIT]              = on_o;
      rdata_o[N_LO+INT_W-1:N_LO]   = stg_n_o;
    end else if (addr_i == TRIM_OFS) begin
      rdata_o[M_LO+FRAC_W-1:M_LO]  = stg_m_o;
    end
  end

  // R6: select frozen while running
  p_sel_locked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |=> $stable(sel_o));
  // R5: request self-clears after transfer
  p_req_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_done_i && !req_set) |=> !req_o);
endmodule

// File: rtl/refclk_core.sv
module refclk_core
  import refclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              on_i,
  input  logic              sw_req_i,
  input  logic [INT_W-1:0]  stg_n_i,
  input  logic [FRAC_W-1:0] stg_m_i,
  output logic              active_o,
  output logic              phase_o,
  output logic              sw_done_o
);
  logic              active_q, phase_q, ext_q;
  logic [INT_W-1:0]  n_q;
  logic [FRAC_W-1:0] m_q, acc_q;
  logic [INT_W:0]    cnt_q, last_cnt;
  logic [FRAC_W:0]   acc_sum;
  logic              pass, edge_hit;

  always_comb begin
    pass      = (n_q == '0);
    acc_sum   = {1'b0, acc_q} + {1'b0, m_q};
    last_cnt  = {1'b0, n_q} + {{INT_W{1'b0}}, ext_q} - {{INT_W{1'b0}}, 1'b1};
    edge_hit  = active_q && tick_i && (pass || (cnt_q == last_cnt));
    sw_done_o = sw_req_i && (!active_q || edge_hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      ext_q    <= 1'b0;
      n_q      <= '0;
      m_q      <= '0;
      acc_q    <= '0;
      cnt_q    <= '0;
    end else begin
      if (sw_done_o) begin
        n_q <= stg_n_i;
        m_q <= stg_m_i;
      end
      if (!active_q) begin
        phase_q  <= 1'b0;
        cnt_q    <= '0;
        acc_q    <= '0;
        ext_q    <= 1'b0;
        active_q <= on_i;
      end else if (edge_hit) begin
        cnt_q <= '0;
        acc_q <= acc_sum[FRAC_W-1:0];
        ext_q <= acc_sum[FRAC_W];
        if (!on_i) begin
          active_q <= 1'b0;
          phase_q  <= 1'b0;
        end else begin
          phase_q <= pass | ~phase_q;
        end
      end else begin
        if (tick_i) cnt_q <= cnt_q + 1'b1;
        if (pass) phase_q <= 1'b0;
      end
    end
  end

  assign active_o = active_q;
  assign phase_o  = phase_q;

  // R7: idle divider keeps its phase low
  p_idle_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !phase_q);
  // R2: tick count never passes the half-period length
  p_half_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !pass) |-> (cnt_q <= {1'b0, n_q}));
  // R4: pass-through pulse follows every tick
  p_pass_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && pass && tick_i && on_i) |=> phase_q);
endmodule

// File: rtl/refclk_frac_div.sv
module refclk_frac_div
  import refclk_pkg::*;
#(
  parameter int NSRC = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              ref_o
);
  logic [SEL_W-1:0]  sel;
  logic              on, oe, req, tick, active, phase, sw_done;
  logic [INT_W-1:0]  stg_n;
  logic [FRAC_W-1:0] stg_m;

  refclk_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .active_i  (active),
    .sw_done_i (sw_done),
    .sel_o     (sel),
    .on_o      (on),
    .oe_o      (oe),
    .req_o     (req),
    .stg_n_o   (stg_n),
    .stg_m_o   (stg_m),
    .rdata_o   (reg_rdata_o)
  );

  refclk_src_mux #(.NSRC(NSRC)) u_mux (
    .src_i  (src_tick_i),
    .sel_i  (sel),
    .tick_o (tick)
  );

  refclk_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .on_i      (on),
    .sw_req_i  (req),
    .stg_n_i   (stg_n),
    .stg_m_i   (stg_m),
    .active_o  (active),
    .phase_o   (phase),
    .sw_done_o (sw_done)
  );

  assign ref_o = phase & oe;
endmodule

// File: tb/tb_refclk_frac_div.sv
module tb_refclk_frac_div;
  localparam int NSRC = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic we = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wdata = '0, rdata;
  logic ref_out;
  int nchk = 0, nfail = 0, cyc = 0;
  string cur_req = "R9";
  logic [7:0] lfsr = 8'h5b;

  refclk_frac_div #(.NSRC(NSRC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ref_o(ref_out));

  always #5 clk = ~clk;

  // source strobes, driven after each edge
  always @(posedge clk) begin
    #2;
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    src[0] = 1'b1;
    src[1] = (cyc % 2) == 0;
    src[2] = (cyc % 3) == 0;
    src[3] = (cyc % 5) == 0;
    src[11:4] = lfsr;
  end

  // behavioural reference
  logic [3:0] m_sel; logic [14:0] m_stgn; logic [8:0] m_stgm;
  logic m_on, m_oe, m_req, m_active, m_phase;
  int m_n, m_m, m_seen, m_acc, m_ext;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_stgn = 0; m_stgm = 0; m_on = 0; m_oe = 0; m_req = 0;
      m_active = 0; m_phase = 0; m_n = 0; m_m = 0; m_seen = 0; m_acc = 0; m_ext = 0;
    end else begin
      automatic bit tk = (m_sel < NSRC) ? src[m_sel] : 1'b0;
      automatic bit done = 0;
      automatic bit was_act = m_active;
      automatic int n_old = m_n;
      if (!m_active) begin
        m_phase = 0; m_seen = 0; m_acc = 0; m_ext = 0;
        if (m_req) begin m_n = m_stgn; m_m = m_stgm; done = 1; end
        m_active = m_on;
      end else if (tk) begin
        if (n_old == 0 || m_seen + 1 == n_old + m_ext) begin
          m_seen = 0;
          m_acc = m_acc + m_m;
          m_ext = (m_acc >= 512) ? 1 : 0;
          m_acc = m_acc % 512;
          if (m_req) begin m_n = m_stgn; m_m = m_stgm; done = 1; end
          if (!m_on) begin m_active = 0; m_phase = 0; end
          else m_phase = (n_old == 0) ? 1'b1 : !m_phase;
        end else m_seen++;
      end else if (n_old == 0) m_phase = 0;
      if (we && addr == 8'h00) begin
        if (!was_act) m_sel = wdata[3:0];
        m_on = wdata[15]; m_oe = wdata[12]; m_stgn = wdata[30:16];
      end
      if (we && addr == 8'h10) m_stgm = wdata[31:23];
      if (we && addr == 8'h00 && wdata[9]) m_req = 1;
      else if (done) m_req = 0;
    end
  end

  function automatic logic [31:0] exp_ctrl();
    return {1'b0, m_stgn, m_on, 2'b00, m_oe, 2'b00, m_req, m_active, 4'h0, m_sel};
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(ref_out == (m_phase & m_oe), cur_req, {31'd0, ref_out}, {31'd0, m_phase & m_oe});
      if (addr == 8'h00) begin
        chk(rdata[8] == m_active, "R7", {31'd0, rdata[8]}, {31'd0, m_active});
        chk(rdata == exp_ctrl(), "R1", rdata, exp_ctrl());
      end
    end
  end

  function automatic logic [31:0] cw(input int sel, input int n, input bit on, input bit oe, input bit sw);
    return (32'(n) << 16) | (32'(on) << 15) | (32'(oe) << 12) | (32'(sw) << 9) | 32'(sel);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2; we = 1; addr = a; wdata = d;
    @(posedge clk); #2; we = 0; addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #2; addr = a; #1; d = rdata; addr = 8'h00;
  endtask

  task automatic wait_rise();
    @(negedge clk);
    while (ref_out) @(negedge clk);
    while (!ref_out) @(negedge clk);
  endtask

  task automatic run_len(input bit lvl, output int n);
    n = 0;
    while (ref_out == lvl) begin n++; @(negedge clk); end
  endtask

  initial begin
    int hi, lo, pulses;
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(ref_out == 0, "R9", {31'd0, ref_out}, 0);
    chk(rdata == 0, "R9", rdata, 0);
    rd(8'h10, d);
    chk(d == 0, "R9", d, 0);

    cur_req = "R1";
    wr(8'h00, cw(0, 3, 0, 1, 0));
    @(negedge clk);
    chk(rdata == 32'h0003_1000, "R1", rdata, 32'h0003_1000);
    wr(8'h10, 32'(9'h05a) << 23);
    rd(8'h10, d);
    chk(d == 32'h2d00_0000, "R1", d, 32'h2d00_0000);
    wr(8'h10, 0);

    cur_req = "R5";
    wr(8'h00, cw(0, 3, 0, 1, 1));
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(rdata[9] == 0, "R5", {31'd0, rdata[9]}, 0);

    cur_req = "R2";
    wr(8'h00, cw(0, 3, 1, 1, 0));
    wait_rise();
    run_len(1, hi);
    run_len(0, lo);
    chk(hi == 3, "R2", hi, 3);
    chk(lo == 3, "R2", lo, 3);

    cur_req = "R5";
    wr(8'h00, cw(0, 5, 1, 1, 0));
    wait_rise();
    run_len(1, hi);
    chk(hi == 3, "R5", hi, 3);
    wr(8'h10, 32'(9'd256) << 23);
    wr(8'h00, cw(0, 2, 1, 1, 1));
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(rdata[9] == 0, "R5", {31'd0, rdata[9]}, 0);

    cur_req = "R3";
    repeat (200) @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      wait_rise();
      run_len(1, hi);
      run_len(0, lo);
      chk(hi + lo == 5, "R3", hi + lo, 5);
    end

    cur_req = "R6";
    wr(8'h00, cw(1, 2, 1, 1, 0));
    @(negedge clk);
    chk(rdata[3:0] == 0, "R6", {28'd0, rdata[3:0]}, 0);

    cur_req = "R8";
    wr(8'h00, cw(0, 2, 1, 0, 0));
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(ref_out == 0, "R8", {31'd0, ref_out}, 0);
    end

    cur_req = "R7";
    wr(8'h00, cw(0, 2, 0, 1, 0));
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(rdata[8] == 0, "R7", {31'd0, rdata[8]}, 0);
    chk(ref_out == 0, "R7", {31'd0, ref_out}, 0);
    wr(8'h00, cw(1, 0, 0, 1, 1));
    @(negedge clk);
    chk(rdata[3:0] == 1, "R6", {28'd0, rdata[3:0]}, 1);

    cur_req = "R4";
    wr(8'h00, cw(1, 0, 1, 1, 0));
    repeat (20) @(posedge clk);
    pulses = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (ref_out) pulses++;
    end
    chk(pulses == 10, "R4", pulses, 10);

    cur_req = "R10";
    wr(8'h00, cw(1, 1, 0, 1, 1));
    repeat (10) @(posedge clk);
    wr(8'h00, cw(3, 1, 1, 1, 0));
    repeat (100) @(posedge clk);
    wr(8'h00, cw(3, 1, 0, 1, 0));
    repeat (20) @(posedge clk);
    wr(8'h00, cw(15, 1, 1, 1, 0));
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk(ref_out == 0, "R10", {31'd0, ref_out}, 0);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule